// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) and returns the full product of `2W` bits. It uses a single `W`-bit adder and spends one clock per multiplier bit. The multiplier operand has no register of its own. It is loaded into the lower half of a double-width accumulator, and the upper half is cleared. On every step the accumulator's least significant bit decides whether the latched multiplicand is added into the upper half. The whole accumulator then moves one place to the right. The adder's carry becomes the new top bit. Once a multiplier bit has been tested it leaves the register, so it is never added again.

A caller drives both operands and pulses `start` while the block is idle. `busy` stays high for exactly `W` cycles. A one-cycle `done` pulse then marks the cycle in which `product` first holds the complete result. The product stays unchanged until the next accepted start. A start that arrives during a run is dropped.

Top module: `seqmul_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high while `busy` is low makes `busy` high in the next cycle.
- R3: `busy` stays high for exactly `W` consecutive cycles after an accepted start. `done` is high in the cycle immediately after the last busy cycle.
- R4: In the `done` cycle, `product` equals the unsigned product of the multiplicand and multiplier that were sampled with the accepted start, over all `2W` bits.
- R5: A `start` pulse while `busy` is high has no effect. The run keeps its original operands and its timing.
- R6: While `busy` is low and no start is accepted, `product` holds its value from one cycle to the next.
- R7: The carry out of each addition is kept. With both operands at their maximum value, the product equals (2^W − 1)^2.
- R8: `done` lasts exactly one cycle and is never high together with `busy`.
- R9: In the first busy cycle, `product` shows the multiplier in bits [W−1:0] and zero in bits [2W−1:W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication; taken only when idle |
| mcand | input | W | Multiplicand, sampled with an accepted start |
| mplier | input | W | Multiplier, sampled with an accepted start |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when `product` is final |
| product | output | 2W | Accumulator; holds the full product after `done` |

## Verification
A wrong iteration count or a fault in the counter moves the `done` pulse by one or more cycles away from `W` cycles after the start. The bench sees this at once, because it counts edges from the accepted start. A lost carry or an add decided from the wrong bit corrupts the product. This is visible in the `done` cycle, and the maximum-value operands expose a dropped carry in the top bit. A start that leaks into a running multiplication, or a bad load image, shows in the first busy cycle or in a product that matches neither operand pair.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqmul_state_e;
endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  import seqmul_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  seqmul_state_e state_q;
  logic [CW-1:0] iter_q;

  assign busy = (state_q == ST_RUN);
  assign load = start && (state_q == ST_IDLE);
  assign step = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            iter_q  <= '0;
          end
        end
        ST_RUN: begin
          if (iter_q == LAST) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            iter_q <= iter_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seqmul_addsel.sv
module seqmul_addsel #(
  parameter int W = 32
) (
  input  logic [W-1:0] upper,
  input  logic [W-1:0] addend,
  input  logic         take,
  output logic [W:0]   sum
);
  logic [W-1:0] gated;

  assign gated = take ? addend : '0;
  assign sum   = {1'b0, upper} + {1'b0, gated};
endmodule

// File: rtl/seqmul_dp.sv
module seqmul_dp #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] acc
);
  localparam int PW = 2 * W;

  logic [W-1:0] mcand_q;
  logic [W:0]   sum;

  seqmul_addsel #(.W(W)) add_i (
    .upper  (acc[PW-1:W]),
    .addend (mcand_q),
    .take   (acc[0]),
    .sum    (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc     <= {{W{1'b0}}, mplier};
      mcand_q <= mcand;
    end else if (step) begin
      acc <= {sum, acc[W-1:1]};
    end
  end
endmodule

// File: rtl/seqmul_top.sv
module seqmul_top #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic load;
  logic step;

  seqmul_ctrl #(.W(W)) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  seqmul_dp #(.W(W)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .mcand  (mcand),
    .mplier (mplier),
    .acc    (product)
  );
endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  logic [2*W-1:0] ref_q;
  int unsigned    run_len_q;
  logic           seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= '0;
      run_len_q <= 0;
      seen_q    <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (start && !busy) begin
        ref_q     <= (2*W)'(mcand) * (2*W)'(mplier);
        run_len_q <= 0;
      end else if (busy) begin
        run_len_q <= run_len_q + 1;
      end
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len_q == W)); // R3
  AST_RESULT: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == ref_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !busy && !start) |=> $stable(product)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(done && busy)); // R8
  AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (product == {{W{1'b0}}, $past(mplier)})); // R9
endmodule

bind seqmul_top seqmul_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/seqmul_top_tb_top.sv
`timescale 1ns/1ps
module seqmul_top_tb_top;
  localparam int WB = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_b = 1'b0, start_s = 1'b0;
  logic [WB-1:0] a_b = '0, b_b = '0;
  logic [WS-1:0] a_s = '0, b_s = '0;
  logic busy_b, done_b, busy_s, done_s;
  logic [2*WB-1:0] p_b;
  logic [2*WS-1:0] p_s;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  seqmul_top #(.W(WB)) dut_i (
    .clk(clk), .rst(rst), .start(start_b), .mcand(a_b), .mplier(b_b),
    .busy(busy_b), .done(done_b), .product(p_b)
  );

  seqmul_top #(.W(WS)) dut_small_i (
    .clk(clk), .rst(rst), .start(start_s), .mcand(a_s), .mplier(b_s),
    .busy(busy_s), .done(done_s), .product(p_s)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // One multiplication on the 32-bit instance; interferes = pulse start mid-run
  task automatic run_b(input logic [WB-1:0] x, input logic [WB-1:0] y,
                       input bit interfere, input string req);
    int n;
    logic [63:0] exp;
    exp = 64'(x) * 64'(y);
    @(negedge clk);
    a_b = x; b_b = y; start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    check(busy_b === 1'b1, "R2", 64'(busy_b), 64'd1);
    check(p_b === {32'd0, y}, "R9", p_b, {32'd0, y});
    n = 0;
    while (done_b !== 1'b1 && n < 100) begin
      if (interfere && n == 5) begin
        a_b = ~x; b_b = ~y; start_b = 1'b1;
      end else begin
        start_b = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_b = 1'b0;
    check(n == WB, "R3", 64'(n), 64'(WB));
    check(busy_b === 1'b0, "R8", 64'(busy_b), 64'd0);
    check(p_b === exp, req, p_b, exp);
    @(negedge clk);
    check(done_b === 1'b0, "R8", 64'(done_b), 64'd0);
  endtask

  task automatic run_s(input logic [WS-1:0] x, input logic [WS-1:0] y);
    int n;
    logic [7:0] exp;
    exp = 8'(x) * 8'(y);
    @(negedge clk);
    a_s = x; b_s = y; start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    n = 0;
    while (done_s !== 1'b1 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == WS, "R3", 64'(n), 64'(WS));
    check(p_s === exp, "R4", 64'(p_s), 64'(exp));
  endtask

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy_b === 1'b0 && done_b === 1'b0, "R1", {busy_b, done_b}, 0);
    check(p_b === '0, "R1", p_b, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy_b === 1'b0 && done_b === 1'b0 && p_b === '0, "R1", p_b, 0);

    // R4: small case 1101 x 1100 = 10011100 on both widths
    run_s(4'b1101, 4'b1100);
    check(p_s === 8'b1001_1100, "R4", 64'(p_s), 64'h9c);
    run_b(32'hd, 32'hc, 1'b0, "R4");

    // R4: exhaustive sweep of the 4-bit instance
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_s(WS'(i), WS'(j));

    // R7: carry retained at maximum operands
    run_b('1, '1, 1'b0, "R7");
    run_b(32'h8000_0000, 32'hffff_ffff, 1'b0, "R7");
    run_b(32'h0, 32'hffff_ffff, 1'b0, "R4");

    // R5: start during a run is ignored
    run_b(32'h1234_5678, 32'h9abc_def0, 1'b1, "R5");

    // R6: product holds while idle
    held = p_b;
    repeat (4) @(negedge clk);
    check(p_b === held, "R6", p_b, held);
    check(busy_b === 1'b0, "R6", 64'(busy_b), 64'd0);

    // R4: pseudo-random operands
    for (int k = 0; k < 120; k++) begin
      logic [31:0] x, y;
      seed = nxt(seed); x = seed;
      seed = nxt(seed); y = seed;
      run_b(x, y, (k % 10) == 3, "R4");
    end

    finish_run();
  end
endmodule